// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel of a 16-bit timer. The counter lives outside the block and is shared by several channels. The block receives the counter value, the counting direction, an up/down-mode flag and the match flag of reference channel 0. It keeps a 16-bit channel value and is programmed through a small byte-wide register port. That port holds a control byte and the two bytes of the channel value.

The channel works in one of two modes.

- **Capture mode:** the channel copies the counter into its value register on the chosen edges of a capture input. The capture input is either an external pin or an alternate event source. The selected input is synchronised before edge detection.
- **Compare mode:** the channel compares the counter with its value register. It drives a compare output according to one of eight action codes. Some codes react to the counting direction, to the counter reaching zero, or to the channel-0 match.

Writes to the value register are staged in two steps. The low byte waits in a holding buffer until the high byte is written. In compare mode, the assembled value then waits until the counter next reads zero before it replaces the active value. An interrupt pulse marks every capture and compare event while the interrupt mask bit is set.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset, the control byte reads 0x40, both value bytes read 0x00, `cmpOut` is 0 and `irqReq` is 0.
- R2: The register address decode is fixed.
  - Address 0 is the control byte. Bit 2 selects the mode (0 capture, 1 compare). Bits 1:0 select the capture edges. Bits 5:3 hold the compare action. Bit 6 is the interrupt mask. Bit 7 selects the alternate capture source.
  - Address 1 reads the active value's low byte, and address 2 reads its high byte.
  - Address 3 reads 0x00.
  - The control byte reads back what was written.
- R3: In capture mode, edge select 01 captures on rising edges, 10 on falling edges, 11 on both edges, and 00 on none.
  - A capture stores the counter value present just before the third rising clock edge after the input changes.
- R4: With control bit 7 set, the capture pin is ignored and edges of `altCapIn` trigger captures instead.
- R5: A write to address 1 only fills a holding buffer and leaves the active value unchanged. A later write to address 2 installs {written high byte, buffered low byte} as one 16-bit value.
- R6: In capture mode, a high-byte write takes effect at the clock edge that accepts it.
  - In compare mode, the value is not changed while the counter is non-zero. It is installed at the first clock edge at which the counter reads 0x0000.
- R7: In compare mode, a counter match with action 000 sets `cmpOut`, with 001 clears it, and with 010 toggles it. The output changes at the clock edge that ends the matching cycle.
- R8: Action 011 depends on the counting mode.
  - With `upDownMode` = 1, it sets `cmpOut` on a match while counting up (`cntDown` = 0) and clears it on a match while counting down. A zero counter has no effect.
  - Otherwise, it sets `cmpOut` on a match and clears it when the counter is 0.
  - Action 100 does the opposite in each case.
- R9: Action 101 clears `cmpOut` on `refMatch` and sets it on this channel's match. Action 110 sets it on `refMatch` and clears it on this channel's match. This channel's match wins when both occur together.
- R10: Action 111 forces `cmpOut` to its initial level 0. In capture mode, `cmpOut` holds its level.
- R11: Each capture, and each compare match in compare mode, gives a one-cycle `irqReq` pulse one clock later, but only when the mask bit is 1. With the mask at 0, `irqReq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntVal | input | 16 | Shared counter value |
| cntDown | input | 1 | 1 while the counter counts down |
| upDownMode | input | 1 | 1 when the counter runs in up/down mode |
| refMatch | input | 1 | Counter equals the channel-0 value |
| capPin | input | 1 | External capture input (asynchronous) |
| altCapIn | input | 1 | Alternate capture source |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 value low, 2 value high |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| cmpOut | output | 1 | Compare output level |
| irqReq | output | 1 | Interrupt request pulse |

## Verification
A wrong active value or pending flag shows up in two ways. The readback at addresses 1 and 2 changes at the wrong clock edge, or a compare match fires at an unexpected counter value one clock after that value is presented. A wrong sampling chain moves the capture by whole cycles, so the bench holds the counter constant and checks the stored value and the pulse on the exact third edge. Errors in action decoding show on `cmpOut` one clock after the triggering counter, reference or direction input. Errors in the mask show as a missing or extra `irqReq` pulse in that same cycle.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

  typedef enum logic [2:0] {
    ACT_SET     = 3'd0,
    ACT_CLR     = 3'd1,
    ACT_TGL     = 3'd2,
    ACT_UP_SET  = 3'd3,
    ACT_UP_CLR  = 3'd4,
    ACT_REF_CLR = 3'd5,
    ACT_REF_SET = 3'd6,
    ACT_INIT    = 3'd7
  } cmpAct_e;

  typedef struct packed {
    logic lowWr;
    logic highNow;
    logic highLater;
    logic capLoad;
    logic outSet;
    logic outClr;
    logic outTgl;
  } ccStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LOW  = 2'd1;
  localparam logic [1:0] ADDR_HIGH = 2'd2;

  localparam int BIT_ALT  = 7;
  localparam int BIT_MASK = 6;
  localparam int BIT_ACT  = 3;
  localparam int BIT_MODE = 2;

endpackage

// File: rtl/tmr_cc_ctrl.sv
module tmr_cc_ctrl
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W     = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              capPin,
  input  logic              altCapIn,
  input  logic              cntDown,
  input  logic              upDownMode,
  input  logic              refMatch,
  input  logic              hitMatch,
  input  logic              cntZero,
  output ccStrobe_t         strobe,
  output logic [BYTE_W-1:0] ctrlReg,
  output logic              irqReq
);

  localparam logic [BYTE_W-1:0] CTRL_RST = BYTE_W'(1) << BIT_MASK;

  logic               modeCmp;
  logic [1:0]         edgeSel;
  cmpAct_e            action;
  logic               srcIn;
  logic [SYNC_STAGES:0] syncQ;
  logic               curLvl, prevLvl;
  logic               edgeHit, capEvent, cmpEvent;

  assign modeCmp = ctrlReg[BIT_MODE];
  assign edgeSel = ctrlReg[1:0];
  assign action  = cmpAct_e'(ctrlReg[BIT_ACT +: 3]);
  assign srcIn   = ctrlReg[BIT_ALT] ? altCapIn : capPin;

  // control byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ctrlReg <= CTRL_RST;
    else if (regWrEn && regAddr == ADDR_CTRL)
      ctrlReg <= regWrData;
  end

  // input synchroniser plus one previous sample for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], srcIn};
  end

  assign curLvl   = syncQ[SYNC_STAGES-1];
  assign prevLvl  = syncQ[SYNC_STAGES];
  assign edgeHit  = (edgeSel[0] && curLvl && !prevLvl) ||
                    (edgeSel[1] && !curLvl && prevLvl);
  assign capEvent = !modeCmp && edgeHit;
  assign cmpEvent = modeCmp && hitMatch;

  always_comb begin
    strobe           = '0;
    strobe.lowWr     = regWrEn && regAddr == ADDR_LOW;
    strobe.highNow   = regWrEn && regAddr == ADDR_HIGH && !modeCmp;
    strobe.highLater = regWrEn && regAddr == ADDR_HIGH && modeCmp;
    strobe.capLoad   = capEvent;
    if (modeCmp) begin
      unique case (action)
        ACT_SET: strobe.outSet = hitMatch;
        ACT_CLR: strobe.outClr = hitMatch;
        ACT_TGL: strobe.outTgl = hitMatch;
        ACT_UP_SET: begin
          if (upDownMode) begin
            strobe.outSet = hitMatch && !cntDown;
            strobe.outClr = hitMatch && cntDown;
          end else begin
            strobe.outSet = hitMatch;
            strobe.outClr = !hitMatch && cntZero;
          end
        end
        ACT_UP_CLR: begin
          if (upDownMode) begin
            strobe.outClr = hitMatch && !cntDown;
            strobe.outSet = hitMatch && cntDown;
          end else begin
            strobe.outClr = hitMatch;
            strobe.outSet = !hitMatch && cntZero;
          end
        end
        ACT_REF_CLR: begin
          strobe.outSet = hitMatch;
          strobe.outClr = !hitMatch && refMatch;
        end
        ACT_REF_SET: begin
          strobe.outClr = hitMatch;
          strobe.outSet = !hitMatch && refMatch;
        end
        ACT_INIT: strobe.outClr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqReq <= 1'b0;
    else       irqReq <= ctrlReg[BIT_MASK] && (capEvent || cmpEvent);
  end

endmodule

// File: rtl/tmr_cc_dpath.sv
module tmr_cc_dpath
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W   = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccStrobe_t         strobe,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  ccVal,
  output logic              hitMatch,
  output logic              cntZero,
  output logic              cmpOut
);

  logic [BYTE_W-1:0] lowBuf;
  logic [CNT_W-1:0]  pendVal;
  logic              pendValid;

  assign hitMatch = (cntVal == ccVal);
  assign cntZero  = (cntVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowBuf <= '0;
    else if (strobe.lowWr) lowBuf <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccVal     <= '0;
      pendVal   <= '0;
      pendValid <= 1'b0;
    end else begin
      if (strobe.highNow)
        ccVal <= {wrByte, lowBuf};
      else if (strobe.capLoad)
        ccVal <= cntVal;
      else if (pendValid && cntZero) begin
        ccVal     <= pendVal;
        pendValid <= 1'b0;
      end
      if (strobe.highLater) begin
        pendVal   <= {wrByte, lowBuf};
        pendValid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cmpOut <= 1'b0;
    else if (strobe.outSet) cmpOut <= 1'b1;
    else if (strobe.outClr) cmpOut <= 1'b0;
    else if (strobe.outTgl) cmpOut <= !cmpOut;
  end

endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W     = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              cntDown,
  input  logic              upDownMode,
  input  logic              refMatch,
  input  logic              capPin,
  input  logic              altCapIn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              cmpOut,
  output logic              irqReq
);

  ccStrobe_t         strobe;
  logic [BYTE_W-1:0] ctrlByte;
  logic [CNT_W-1:0]  ccActive;
  logic              hitMatch, cntZero;

  tmr_cc_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .capPin(capPin), .altCapIn(altCapIn),
    .cntDown(cntDown), .upDownMode(upDownMode), .refMatch(refMatch),
    .hitMatch(hitMatch), .cntZero(cntZero), .strobe(strobe),
    .ctrlReg(ctrlByte), .irqReq(irqReq)
  );

  tmr_cc_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(regWrData),
    .cntVal(cntVal), .ccVal(ccActive), .hitMatch(hitMatch),
    .cntZero(cntZero), .cmpOut(cmpOut)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = ctrlByte;
      ADDR_LOW:  regRdData = ccActive[BYTE_W-1:0];
      ADDR_HIGH: regRdData = ccActive[CNT_W-1:BYTE_W];
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk #(
  parameter int CNT_W   = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  cntVal,
  input logic              cmpOut,
  input logic              irqReq,
  input logic [BYTE_W-1:0] ctrlByte,
  input logic [CNT_W-1:0]  ccActive
);

  logic isCmp;
  logic [2:0] act;
  assign isCmp = ctrlByte[2];
  assign act   = ctrlByte[5:3];

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlByte[6] |=> !irqReq); // R11
  AST_DEFER_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (isCmp && cntVal != '0) |=> $stable(ccActive)); // R6
  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (isCmp && act == 3'b000 && cntVal == ccActive) |=> cmpOut); // R7
  AST_CLR_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (isCmp && act == 3'b001 && cntVal == ccActive) |=> !cmpOut); // R7
  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (isCmp && act == 3'b010 && cntVal == ccActive) |=> cmpOut != $past(cmpOut)); // R7
  AST_FORCE_INIT: assert property (@(posedge clk) disable iff (!rstN)
    (isCmp && act == 3'b111) |=> !cmpOut); // R10
  AST_CAPTURE_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !isCmp |=> $stable(cmpOut)); // R10

endmodule

bind tmr_cc_channel tmr_cc_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .cntVal(cntVal), .cmpOut(cmpOut),
  .irqReq(irqReq), .ctrlByte(ctrlByte), .ccActive(ccActive)
);

// File: tb/test_tmr_cc_channel.sv
`timescale 1ns/1ps
module test_tmr_cc_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cntVal = 16'h0050;
  logic        cntDown = 1'b0, upDownMode = 1'b0, refMatch = 1'b0;
  logic        capPin = 1'b0, altCapIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic        cmpOut, irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_cc_channel i_tmr_cc_channel (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .cntDown(cntDown),
    .upDownMode(upDownMode), .refMatch(refMatch), .capPin(capPin),
    .altCapIn(altCapIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmpOut(cmpOut),
    .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [15:0] v);
    cntVal = v;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdVal(output logic [15:0] v);
    regAddr = 2'd1; #1; v[7:0] = regRdData;
    regAddr = 2'd2; #1; v[15:8] = regRdData;
  endtask

  task automatic loadVal(input logic [15:0] v);
    cntVal = 16'h0050;
    wr(2'd0, 8'h40);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic setAct(input logic [2:0] a);
    cntVal = 16'h0050;
    wr(2'd0, 8'h44 | {2'b00, a, 3'b000});
  endtask

  task automatic testReset();
    logic [15:0] v;
    regAddr = 2'd0; #1;
    check("R1 ctrl", {8'h0, regRdData}, 16'h0040);
    rdVal(v);
    check("R1 value", v, 16'h0000);
    check("R1 cmpOut", {15'h0, cmpOut}, 16'h0);
    check("R1 irq", {15'h0, irqReq}, 16'h0);
  endtask

  task automatic testRegs();
    wr(2'd0, 8'h3B);
    regAddr = 2'd0; #1;
    check("R2 ctrl readback", {8'h0, regRdData}, 16'h003B);
    regAddr = 2'd3; #1;
    check("R2 addr3 zero", {8'h0, regRdData}, 16'h0000);
    wr(2'd0, 8'h40);
  endtask

  task automatic testCapture();
    logic [15:0] v;
    wr(2'd0, 8'h41);
    capPin = 1'b1;
    tick(16'h1234); tick(16'h1234);
    rdVal(v);
    check("R3 not yet captured", v, 16'h0000);
    tick(16'h1234);
    rdVal(v);
    check("R3 rising capture", v, 16'h1234);
    check("R11 capture irq", {15'h0, irqReq}, 16'h1);
    tick(16'h1234);
    check("R11 irq one cycle", {15'h0, irqReq}, 16'h0);
    capPin = 1'b0;
    repeat (4) tick(16'h5555);
    rdVal(v);
    check("R3 falling ignored on 01", v, 16'h1234);
    wr(2'd0, 8'h42);
    capPin = 1'b1;
    repeat (4) tick(16'h2222);
    rdVal(v);
    check("R3 rising ignored on 10", v, 16'h1234);
    capPin = 1'b0;
    repeat (4) tick(16'h2222);
    rdVal(v);
    check("R3 falling capture", v, 16'h2222);
    wr(2'd0, 8'h43);
    capPin = 1'b1;
    repeat (4) tick(16'h3333);
    rdVal(v);
    check("R3 both rising", v, 16'h3333);
    capPin = 1'b0;
    repeat (4) tick(16'h4444);
    rdVal(v);
    check("R3 both falling", v, 16'h4444);
    wr(2'd0, 8'h40);
    capPin = 1'b1;
    repeat (4) tick(16'h4545);
    capPin = 1'b0;
    repeat (4) tick(16'h4646);
    rdVal(v);
    check("R3 select 00 none", v, 16'h4444);
  endtask

  task automatic testAlt();
    logic [15:0] v;
    wr(2'd0, 8'hC1);
    capPin = 1'b1;
    repeat (4) tick(16'h6666);
    rdVal(v);
    check("R4 pin ignored", v, 16'h4444);
    altCapIn = 1'b1;
    repeat (3) tick(16'h7777);
    rdVal(v);
    check("R4 alt capture", v, 16'h7777);
    altCapIn = 1'b0;
    capPin = 1'b0;
    repeat (4) tick(16'h7878);
    wr(2'd0, 8'h01);
    capPin = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(16'h8888);
      check("R11 masked capture irq", {15'h0, irqReq}, 16'h0);
    end
    rdVal(v);
    check("R11 masked capture still stores", v, 16'h8888);
    capPin = 1'b0;
    repeat (4) tick(16'h8888);
  endtask

  task automatic testBuffer();
    logic [15:0] v;
    loadVal(16'h0100);
    rdVal(v);
    check("R6 immediate in capture", v, 16'h0100);
    wr(2'd1, 8'h77);
    rdVal(v);
    check("R5 low write staged", v, 16'h0100);
    setAct(3'd0);
    wr(2'd1, 8'hCD);
    wr(2'd2, 8'hAB);
    rdVal(v);
    check("R6 deferred after write", v, 16'h0100);
    tick(16'h0051);
    rdVal(v);
    check("R6 held while nonzero", v, 16'h0100);
    tick(16'h0000);
    rdVal(v);
    check("R5 R6 installed at zero", v, 16'hABCD);
  endtask

  task automatic testActions();
    loadVal(16'h0100);
    setAct(3'd0);
    tick(16'h0100);
    check("R7 set on match", {15'h0, cmpOut}, 16'h1);
    check("R11 compare irq", {15'h0, irqReq}, 16'h1);
    setAct(3'd1);
    tick(16'h0100);
    check("R7 clear on match", {15'h0, cmpOut}, 16'h0);
    setAct(3'd2);
    tick(16'h0100);
    check("R7 toggle 1", {15'h0, cmpOut}, 16'h1);
    tick(16'h0100);
    check("R7 toggle 2", {15'h0, cmpOut}, 16'h0);
    tick(16'h0050);
    check("R7 hold no match", {15'h0, cmpOut}, 16'h0);
    setAct(3'd3);
    tick(16'h0100);
    check("R8 011 set on match", {15'h0, cmpOut}, 16'h1);
    tick(16'h0000);
    check("R8 011 clear at zero", {15'h0, cmpOut}, 16'h0);
    upDownMode = 1'b1;
    tick(16'h0100);
    check("R8 011 ud up set", {15'h0, cmpOut}, 16'h1);
    tick(16'h0000);
    check("R8 011 ud zero no effect", {15'h0, cmpOut}, 16'h1);
    cntDown = 1'b1;
    tick(16'h0100);
    check("R8 011 ud down clear", {15'h0, cmpOut}, 16'h0);
    setAct(3'd4);
    tick(16'h0100);
    check("R8 100 ud down set", {15'h0, cmpOut}, 16'h1);
    cntDown = 1'b0;
    tick(16'h0100);
    check("R8 100 ud up clear", {15'h0, cmpOut}, 16'h0);
    upDownMode = 1'b0;
    tick(16'h0000);
    check("R8 100 set at zero", {15'h0, cmpOut}, 16'h1);
    tick(16'h0100);
    check("R8 100 clear on match", {15'h0, cmpOut}, 16'h0);
    setAct(3'd5);
    tick(16'h0100);
    check("R9 101 set on match", {15'h0, cmpOut}, 16'h1);
    refMatch = 1'b1;
    tick(16'h0050);
    refMatch = 1'b0;
    check("R9 101 clear on ref", {15'h0, cmpOut}, 16'h0);
    setAct(3'd6);
    refMatch = 1'b1;
    tick(16'h0050);
    refMatch = 1'b0;
    check("R9 110 set on ref", {15'h0, cmpOut}, 16'h1);
    tick(16'h0100);
    check("R9 110 clear on match", {15'h0, cmpOut}, 16'h0);
    setAct(3'd0);
    tick(16'h0100);
    setAct(3'd7);
    tick(16'h0050);
    check("R10 111 forces 0", {15'h0, cmpOut}, 16'h0);
    setAct(3'd0);
    tick(16'h0100);
    cntVal = 16'h0050;
    wr(2'd0, 8'h40);
    tick(16'h0100);
    check("R10 capture mode holds", {15'h0, cmpOut}, 16'h1);
    check("R11 no irq in capture mode", {15'h0, irqReq}, 16'h0);
    cntVal = 16'h0050;
    wr(2'd0, 8'h0C);
    tick(16'h0100);
    check("R11 masked compare irq", {15'h0, irqReq}, 16'h0);
    check("R7 masked compare still clears", {15'h0, cmpOut}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testRegs();
    testCapture();
    testAlt();
    testBuffer();
    testActions();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule